// File: doc/BRIEF.md
# Synchronous Serial Receive Controller

This block is the receive side of a clocked synchronous serial port. It turns a stream of serial bits into bytes, MSB first, and hands each byte to a host through a small register set. It runs in one of two roles. As clock master it drives the serial clock from a divided system clock, and it produces exactly one byte of clocks each time the host reads the receive data register while reception is enabled. As clock slave it takes the clock from outside and shifts only while the select input is low. The slave's clock, select and data inputs first pass through a synchronizer.

A complete byte is placed in the data register and raises a full flag. If a byte completes while the previous one is still unread, the overrun flag is set and that new byte is dropped. Reception then stays frozen until the host clears the flag. To end a master transfer cleanly, the host sets a stop request. The byte that the next read starts becomes the last one, and when it completes, both the enable and the stop request drop by themselves.

Top module: `sync_rx_ctrl`

## Requirements
- R1: The host sees four registers, selected by `host_addr`. Address 0 is the receive data register (read). Address 1 is the control/status register, with bit 0 enable, bit 1 stop request, bit 2 interrupt enable, bit 3 master role, bit 4 clock phase, bit 5 full flag (read only) and bit 6 overrun flag. Address 2 is the divide ratio. Address 3 reads 0. After reset, every register reads 0, both interrupt outputs are 0, and `sclk_o` and `sclk_oe` are 0.
- R2: In the master role, a read of address 0 while enable is 1 and overrun is 0 produces exactly 8 high pulses on `sclk_o`. Each half period lasts divide ratio + 1 system clocks, and the clock idles low. A read while enable is 0 produces no clock.
- R3: Bits are taken MSB first. With phase 0 a bit is sampled at a rising serial-clock edge, and with phase 1 at a falling edge. After the eighth sample, the byte is placed in the data register and the full flag sets.
- R4: `rx_irq` is high exactly while the full flag and interrupt enable are both 1.
- R5: A read of the data register clears the full flag.
- R6: In the master role, a read of the data register while enable is 1 and stop request is 0 starts another byte of clocks.
- R7: A master byte started while stop request is 1 is the final one. When it completes, enable and stop request both read 0, and later reads of the data register produce no clock.
- R8: In the slave role, bits are taken only on synchronized `sclk_i` edges while `ss_n_i` is low. While `ss_n_i` is high, clock edges are ignored and the bit count returns to zero.
- R9: If an eighth sample occurs while the full flag is 1, the overrun flag sets and the new byte is dropped, so the data register keeps the unread byte. `err_irq` is high while overrun and interrupt enable are both 1.
- R10: While the overrun flag is 1, no byte is received in the slave role, and no clock is started in the master role.
- R11: The overrun flag clears only when 0 is written to bit 6 of address 1. Writing 1 there leaves it unchanged.
- R12: In the master role with phase 0, the full flag sets while the final `sclk_o` pulse is still high. With phase 1, it sets at the final falling edge, once the clock is back low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 2 | Register select |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (read side effects) |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data for the selected register |
| sclk_o | output | 1 | Serial clock driven in the master role |
| sclk_oe | output | 1 | High when the block drives the serial clock |
| sclk_i | input | 1 | Serial clock from outside in the slave role |
| ss_n_i | input | 1 | Active-low select in the slave role |
| sdi_i | input | 1 | Serial data in |
| rx_irq | output | 1 | Receive-full interrupt |
| err_irq | output | 1 | Overrun interrupt |

## Verification
The bench builds the block with an 8-bit byte, a 4-bit divide ratio and two synchronizer stages. The narrow ratio keeps a master byte to a few dozen cycles, so one run can cover divide ratios 0 through 3, both phases, back-to-back master bytes and the stop-terminated final byte. The default synchronizer depth lets the slave tests use a four-cycle half period and still reach an overrun, a dropped byte, a partial byte cut off by select, and recovery after the flag is cleared.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [1:0] {
        ADDR_DATA = 2'd0,
        ADDR_CTRL = 2'd1,
        ADDR_DIV  = 2'd2,
        ADDR_RSVD = 2'd3
    } reg_addr_e;

    localparam int CB_EN   = 0;
    localparam int CB_STOP = 1;
    localparam int CB_RIE  = 2;
    localparam int CB_MST  = 3;
    localparam int CB_CPHA = 4;
    localparam int CB_FULL = 5;
    localparam int CB_OVR  = 6;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int         WIDTH  = 3,
    parameter int         STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign sync_out = stg_q[STAGES-1];

endmodule

// File: rtl/srx_mclk.sv
module srx_mclk #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] div,
    input  logic             cpha,
    output logic             sclk,
    output logic             busy,
    output logic             sample
);

    localparam int TOG_W = $clog2(2 * DATA_W);
    localparam logic [TOG_W-1:0] TOG_LAST = TOG_W'(2 * DATA_W - 1);

    typedef struct packed {
        logic             busy;
        logic             sclk;
        logic [DIV_W-1:0] cnt;
        logic [TOG_W-1:0] tog;
    } mclk_t;

    mclk_t q, d;
    logic  edge_now;

    always_comb begin
        edge_now = q.busy && (q.cnt == div);
        sample   = edge_now && (cpha ? q.sclk : !q.sclk);
        d = q;
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.cnt  = '0;
                d.tog  = '0;
            end
        end else if (edge_now) begin
            d.cnt  = '0;
            d.sclk = !q.sclk;
            d.tog  = q.tog + 1'b1;
            if (q.tog == TOG_LAST) begin
                d.busy = 1'b0;
            end
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sclk = q.sclk;
    assign busy = q.busy;

    // R2: the serial clock rests low whenever no byte is in flight
    p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> !q.sclk);

    // R2: no clock edge before the half period has been counted out
    p_half_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && (q.cnt != div)) |=> $stable(q.sclk));

endmodule

// File: rtl/srx_shift.sv
module srx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              din,
    output logic              byte_done,
    output logic [DATA_W-1:0] byte_val
);

    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-2:0] sr;
    } shift_t;

    shift_t q, d;
    logic   at_last;

    always_comb begin
        at_last   = (q.cnt == CNT_LAST);
        byte_done = sample && at_last && !clear;
        byte_val  = {q.sr, din};
        d = q;
        if (clear) begin
            d.cnt = '0;
        end else if (sample) begin
            d.sr  = {q.sr[DATA_W-3:0], din};
            d.cnt = at_last ? '0 : q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R3: a finished byte starts the next count from zero
    p_count_wraps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> (q.cnt == '0));

    // R8: a clear always returns the bit count to zero
    p_clear_resets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (q.cnt == '0));

endmodule

// File: rtl/sync_rx_ctrl.sv
module sync_rx_ctrl #(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              sclk_o,
    output logic              sclk_oe,
    input  logic              sclk_i,
    input  logic              ss_n_i,
    input  logic              sdi_i,
    output logic              rx_irq,
    output logic              err_irq
);

    import srx_pkg::*;

    typedef struct packed {
        logic              en;
        logic              stop;
        logic              rie;
        logic              mst;
        logic              cpha;
        logic              full;
        logic              ovr;
        logic              last;
        logic              sclk_prev;
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] data;
    } regs_t;

    regs_t q, d;

    reg_addr_e   addr;
    logic        rd_data, ctrl_wr, div_wr;
    logic        m_start, m_busy, m_sample, m_sclk;
    logic [2:0]  sync_bus;
    logic        s_sclk, s_ssn, s_sdi;
    logic        s_rise, s_fall, s_sample;
    logic        sh_clear, sh_sample, sh_din, byte_done;
    logic [DATA_W-1:0] byte_val;

    assign addr    = reg_addr_e'(host_addr);
    assign rd_data = host_rd && (addr == ADDR_DATA);
    assign ctrl_wr = host_wr && (addr == ADDR_CTRL);
    assign div_wr  = host_wr && (addr == ADDR_DIV);

    srx_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sclk_i, ss_n_i, sdi_i}),
        .sync_out (sync_bus)
    );

    assign {s_sclk, s_ssn, s_sdi} = sync_bus;
    assign s_rise   = s_sclk && !q.sclk_prev;
    assign s_fall   = !s_sclk && q.sclk_prev;
    assign s_sample = !q.mst && q.en && !q.ovr && !s_ssn && (q.cpha ? s_fall : s_rise);

    assign m_start  = rd_data && q.en && q.mst && !q.ovr && !m_busy;

    srx_mclk #(
        .DATA_W (DATA_W),
        .DIV_W  (DIV_W)
    ) u_mclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (m_start),
        .div    (q.div),
        .cpha   (q.cpha),
        .sclk   (m_sclk),
        .busy   (m_busy),
        .sample (m_sample)
    );

    assign sh_clear  = q.mst ? !m_busy : s_ssn;
    assign sh_sample = q.mst ? m_sample : s_sample;
    assign sh_din    = q.mst ? sdi_i : s_sdi;

    srx_shift #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (sh_clear),
        .sample    (sh_sample),
        .din       (sh_din),
        .byte_done (byte_done),
        .byte_val  (byte_val)
    );

    always_comb begin
        d = q;
        d.sclk_prev = s_sclk;
        if (m_start) begin
            d.last = q.stop;
        end
        if (rd_data) begin
            d.full = 1'b0;
        end
        if (byte_done) begin
            if (q.full && !rd_data) begin
                d.ovr = 1'b1;
            end else begin
                d.data = byte_val;
                d.full = 1'b1;
            end
            if (q.mst && q.last) begin
                d.en   = 1'b0;
                d.stop = 1'b0;
                d.last = 1'b0;
            end
        end
        if (ctrl_wr) begin
            d.en   = host_wdata[CB_EN];
            d.stop = host_wdata[CB_STOP];
            d.rie  = host_wdata[CB_RIE];
            d.mst  = host_wdata[CB_MST];
            d.cpha = host_wdata[CB_CPHA];
            if (!host_wdata[CB_OVR]) begin
                d.ovr = 1'b0;
            end
        end
        if (div_wr) begin
            d.div = host_wdata[DIV_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        host_rdata = '0;
        case (addr)
            ADDR_DATA: host_rdata = q.data;
            ADDR_CTRL: begin
                host_rdata[CB_EN]   = q.en;
                host_rdata[CB_STOP] = q.stop;
                host_rdata[CB_RIE]  = q.rie;
                host_rdata[CB_MST]  = q.mst;
                host_rdata[CB_CPHA] = q.cpha;
                host_rdata[CB_FULL] = q.full;
                host_rdata[CB_OVR]  = q.ovr;
            end
            ADDR_DIV:  host_rdata = DATA_W'(q.div);
            default:   host_rdata = '0;
        endcase
    end

    assign sclk_o  = m_sclk;
    assign sclk_oe = q.mst;
    assign rx_irq  = q.full && q.rie;
    assign err_irq = q.ovr && q.rie;

    // R5: reading the data register empties it unless a byte lands at once
    p_read_clears_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !byte_done) |=> !q.full);

    // R9: a byte finishing into a full register flags overrun and is dropped
    p_overrun_keeps_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && q.full && !rd_data && !ctrl_wr) |=> (q.ovr && $stable(q.data)));

    // R7: the final master byte drops enable and the stop request
    p_last_byte_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && q.mst && q.last && !ctrl_wr) |=> (!q.en && !q.stop));

    // R11: overrun survives every cycle without a clearing write
    p_ovr_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ovr && !(ctrl_wr && !host_wdata[CB_OVR])) |=> q.ovr);

    // R10: no master clock burst begins while overrun is pending
    p_no_burst_in_ovr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ovr && !m_busy) |=> !m_busy);

endmodule

// File: tb/sync_rx_ctrl_bench.sv
`timescale 1ns/1ps
module sync_rx_ctrl_bench;

    localparam int DW = 8;
    localparam int VW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    host_addr = 2'd0;
    logic          host_wr = 1'b0;
    logic          host_rd = 1'b0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          sclk_o, sclk_oe, rx_irq, err_irq;
    logic          slv_sclk = 1'b0;
    logic          slv_ss = 1'b1;
    logic          slv_sdi = 1'b0;
    logic          use_model = 1'b1;
    logic          model_bit;
    logic          tb_cpha = 1'b0;
    logic [7:0]    tx_byte = 8'h00;
    int            rise_cnt = 0;
    int            fall_cnt = 0;
    int            rise_base = 0;
    int            fall_base = 0;
    int            checks = 0;
    int            fails = 0;
    bit            finished = 1'b0;

    always #2.5 clk = ~clk;

    sync_rx_ctrl #(
        .DATA_W      (DW),
        .DIV_W       (VW),
        .SYNC_STAGES (2)
    ) u_sync_rx_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .sclk_o     (sclk_o),
        .sclk_oe    (sclk_oe),
        .sclk_i     (slv_sclk),
        .ss_n_i     (slv_ss),
        .sdi_i      (use_model ? model_bit : slv_sdi),
        .rx_irq     (rx_irq),
        .err_irq    (err_irq)
    );

    // Remote transmitter model for master tests: phase 0 shifts after falling
    // edges, phase 1 presents each bit at the rising edge.
    always @(posedge sclk_o) rise_cnt <= rise_cnt + 1;
    always @(negedge sclk_o) fall_cnt <= fall_cnt + 1;

    always_comb begin
        int idx;
        if (!tb_cpha) idx = 7 - (fall_cnt - fall_base);
        else          idx = 8 - (rise_cnt - rise_base);
        model_bit = (idx >= 0 && idx <= 7) ? tx_byte[idx] : 1'b0;
    end

    // {rie, cpha, div[3:0], byte[7:0]}
    localparam logic [13:0] VEC [5] = '{
        {1'b1, 1'b0, 4'd1, 8'hA5},
        {1'b1, 1'b1, 4'd1, 8'h3C},
        {1'b0, 1'b0, 4'd3, 8'h81},
        {1'b1, 1'b1, 4'd2, 8'h7E},
        {1'b1, 1'b0, 4'd0, 8'hFF}
    };

    function automatic logic [7:0] cw(bit en, bit stop, bit rie, bit mst, bit cpha, bit ovr);
        return {1'b0, ovr, 1'b0, cpha, mst, rie, stop, en};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_write(logic [1:0] a, logic [7:0] v);
        @(negedge clk);
        host_addr = a; host_wdata = v; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic host_read(logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 v = host_rdata;
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(int div, output int hi, output bit seen, output logic sclk_at);
        hi = 0; seen = 1'b0; sclk_at = 1'b0;
        repeat (16 * (div + 1) + 6) begin
            @(negedge clk);
            if (sclk_o) hi++;
            if (rx_irq && !seen) begin
                seen = 1'b1;
                sclk_at = sclk_o;
            end
        end
    endtask

    task automatic arm_model(logic [7:0] b);
        tx_byte = b;
        rise_base = rise_cnt;
        fall_base = fall_cnt;
    endtask

    task automatic slave_byte(logic [7:0] b, bit cpha, int nbits);
        slv_ss = 1'b0;
        idle(4);
        for (int i = 7; i > 7 - nbits; i--) begin
            if (!cpha) begin
                slv_sdi = b[i]; idle(4);
                slv_sclk = 1'b1; idle(4);
                slv_sclk = 1'b0;
            end else begin
                slv_sclk = 1'b1; slv_sdi = b[i]; idle(4);
                slv_sclk = 1'b0; idle(4);
            end
        end
        idle(4);
        slv_ss = 1'b1;
        idle(6);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] v;
        int hi, rb;
        bit seen;
        logic sclk_at;

        idle(3);
        // R1: reset values
        chk("R1 irq", {30'd0, rx_irq, err_irq}, 32'd0);
        chk("R1 sclk", {30'd0, sclk_o, sclk_oe}, 32'd0);
        rst_n = 1'b1;
        idle(2);
        host_read(2'd1, v); chk("R1 ctrl", v, 8'h00);
        host_read(2'd0, v); chk("R1 data", v, 8'h00);
        host_read(2'd2, v); chk("R1 div",  v, 8'h00);
        host_read(2'd3, v); chk("R1 rsvd", v, 8'h00);

        // Master table: R2 R3 R4 R5 R12
        for (int k = 0; k < 5; k++) begin
            bit rie, cp;
            int dv;
            logic [7:0] b;
            rie = VEC[k][13]; cp = VEC[k][12]; dv = int'(VEC[k][11:8]); b = VEC[k][7:0];
            host_write(2'd2, 8'(dv));
            host_write(2'd1, cw(1, 0, rie, 1, cp, 0));
            tb_cpha = cp;
            arm_model(b);
            host_read(2'd0, v);
            frame(dv, hi, seen, sclk_at);
            chk("R2 pulse count", rise_cnt - rise_base, 8);
            chk("R2 high cycles", hi, 8 * (dv + 1));
            host_read(2'd1, v); chk("R3 full set", v[5], 1'b1);
            chk("R4 rx_irq", rx_irq, rie);
            if (rie) chk("R12 flag timing", sclk_at, !cp);
            host_write(2'd1, cw(0, 0, rie, 1, cp, 0));
            rb = rise_cnt;
            host_read(2'd0, v); chk("R3 data", v, b);
            idle(12);
            chk("R2 no clock when disabled", rise_cnt, rb);
            host_read(2'd1, v); chk("R5 full cleared", v[5], 1'b0);
            chk("R4 rx_irq low", rx_irq, 1'b0);
        end

        // R6 back-to-back master bytes, then R7 stop-terminated last byte
        host_write(2'd2, 8'd1);
        host_write(2'd1, cw(1, 0, 1, 1, 0, 0));
        tb_cpha = 1'b0;
        arm_model(8'h12);
        host_read(2'd0, v);
        frame(1, hi, seen, sclk_at);
        arm_model(8'h34);
        host_read(2'd0, v); chk("R6 first byte", v, 8'h12);
        frame(1, hi, seen, sclk_at);
        chk("R6 next burst", rise_cnt - rise_base, 8);
        host_write(2'd1, cw(1, 1, 1, 1, 0, 0));
        arm_model(8'hC9);
        host_read(2'd0, v); chk("R6 second byte", v, 8'h34);
        frame(1, hi, seen, sclk_at);
        chk("R7 final burst", rise_cnt - rise_base, 8);
        host_read(2'd1, v); chk("R7 en/stop cleared", {v[5], v[1], v[0]}, 3'b100);
        rb = rise_cnt;
        host_read(2'd0, v); chk("R7 last byte", v, 8'hC9);
        idle(12);
        chk("R7 no further clock", rise_cnt, rb);

        // Slave role: R8 R9 R10 R11
        use_model = 1'b0;
        host_write(2'd1, cw(1, 0, 1, 0, 0, 0));
        chk("R8 sclk_oe low", sclk_oe, 1'b0);
        for (int i = 0; i < 8; i++) begin
            slv_sdi = i[0]; idle(4); slv_sclk = 1'b1; idle(4); slv_sclk = 1'b0;
        end
        idle(6);
        host_read(2'd1, v); chk("R8 ignored while deselected", v[5], 1'b0);
        slave_byte(8'hFF, 0, 3);
        slave_byte(8'hC3, 0, 8);
        host_read(2'd1, v); chk("R8 full after byte", v[5], 1'b1);
        slave_byte(8'h99, 0, 8);
        host_read(2'd1, v); chk("R9 overrun flag", v[6], 1'b1);
        chk("R9 err_irq", err_irq, 1'b1);
        host_read(2'd0, v); chk("R9 kept byte", v, 8'hC3);
        slave_byte(8'h11, 0, 8);
        host_read(2'd1, v); chk("R10 no slave receive", v[5], 1'b0);
        host_write(2'd1, cw(1, 0, 1, 0, 0, 1));
        host_read(2'd1, v); chk("R11 write 1 ignored", v[6], 1'b1);
        host_write(2'd1, cw(1, 0, 1, 1, 0, 1));
        rb = rise_cnt;
        host_read(2'd0, v);
        idle(40);
        chk("R10 no master clock", rise_cnt, rb);
        host_write(2'd1, cw(1, 0, 1, 0, 1, 0));
        host_read(2'd1, v); chk("R11 write 0 clears", v[6], 1'b0);
        chk("R11 err_irq low", err_irq, 1'b0);
        slave_byte(8'h5A, 1, 8);
        host_read(2'd0, v); chk("R3 slave phase 1 byte", v, 8'h5A);

        summary();
    end

endmodule